// File: doc/BRIEF.md
# Buffered SPI Master

This block is a register-mapped SPI master for a host bus. Software first parks it in configuration mode, where it sets the clock polarity, clock phase, bit order, baud divisor, frame length and receive fill threshold. It then switches the block to active mode. Each byte written to the data register goes into a small transmit queue. The serial engine shifts it out on the serial clock and data-out lines and captures one byte from the data-in line in return. Captured bytes are held in a receive queue, and software pops them by reading the data register.

A receive-ready flag rises once the receive queue holds a programmable number of bytes, from 1 to 4. The number is programmed as the count minus one. That flag, together with an enable bit, drives the interrupt line. Chip-select generation and its timing stay outside the block.

Top module: `spi_burst_master`

## Requirements
- R1: After reset the block is in configuration mode and reads back as follows: mode register (address 0) = 0x0000, framing register (address 1) = 0x0000, clock/length register (address 2) = 0x0008 (divisor 0, 8-bit frames), status register (address 3) = 0x0011. The irq output and SCLK are low.
- R2: The framing and clock/length registers accept writes only in configuration mode. A write to either of them in active mode leaves the read-back value unchanged.
- R3: Mode register bit 0 selects active mode (1) or configuration mode (0). A mode write with bit 0 = 0 and bit 1 = 1 empties both queues and clears the overflow flag. Bytes discarded this way are never transmitted.
- R4: Bytes are shifted only in active mode. In configuration mode, written bytes wait in the transmit queue and SCLK does not toggle.
- R5: The clock/length register holds the divisor in bits [15:8] and the frame length in bits [3:0]. Each SCLK half period lasts divisor+1 clock cycles, and a byte takes exactly 16 SCLK edges. Between frames SCLK rests at the polarity bit (framing bit 1).
- R6: The phase bit is framing bit 2. With phase 0, MOSI is valid before the first leading edge and changes on trailing edges, and MISO is sampled on leading edges. With phase 1, MOSI changes on leading edges and MISO is sampled on trailing edges. All four polarity/phase combinations exchange data correctly.
- R7: Framing bit 0 set to 1 sends and receives least-significant bit first. Set to 0, it sends and receives most-significant bit first.
- R8: Every transmitted byte yields one received byte. Reads of the data register (address 4) return received bytes in arrival order. A read with the receive queue empty returns 0.
- R9: The transmit queue holds 4 bytes. A data write to a full queue is dropped and sets status bit 2, which stays set until cleared as in R3.
- R10: Status bit 1 (receive ready) is set while the receive queue holds at least T+1 bytes, where T is framing bits [13:12].
- R11: Framing bit 3 enables the interrupt. The irq output is high one cycle after both the enable and receive ready are set, and is low otherwise.
- R12: Status bit 0 (idle) is set when no frame is shifting and the transmit queue is empty. Status bit 3 reports a full transmit queue, bit 4 an empty receive queue, and bit 5 active mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after the strobe |
| irq | output | 1 | Receive interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench runs a model of an SPI slave through all four clock modes, in both bit orders and at several divisors. Swapping the leading and trailing edges would corrupt the byte the slave captures, and a divisor off by one would show up in the measured half period. Other tests stage five bytes in configuration mode. A design that shifts in the wrong mode would toggle SCLK too early, and one without overflow handling would send the fifth byte or fail to latch the overflow flag. The bench also checks the receive threshold exactly at T and T+1 entries, with the enable bit on and off, which exposes an off-by-one or an ungated interrupt. Finally, it reads from an empty receive queue and writes the control registers in active mode.

// File: rtl/spibm_pkg.sv
package spibm_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_MODE   = 3'd0,
    A_FRAME  = 3'd1,
    A_CLKLEN = 3'd2,
    A_STAT   = 3'd3,
    A_DATA   = 3'd4
  } reg_addr_e;

  // mode register bits
  localparam int MD_ACT = 0;
  localparam int MD_CLR = 1;
  // framing register bits
  localparam int FR_LSB   = 0;
  localparam int FR_CPOL  = 1;
  localparam int FR_CPHA  = 2;
  localparam int FR_IRQEN = 3;
  localparam int FR_THR   = 12;
  // clock/length register
  localparam int CL_DIV = 8;
  localparam int LEN_W  = 4;
  // status bits
  localparam int ST_IDLE  = 0;
  localparam int ST_RXRDY = 1;
  localparam int ST_OVF   = 2;
  localparam int ST_TXFUL = 3;
  localparam int ST_RXEMP = 4;
  localparam int ST_ACT   = 5;
endpackage

// File: rtl/spibm_fifo.sv
module spibm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty,
  output logic [AW:0]  count
);
  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assign rdata = mem[rd_ptr[AW-1:0]];
  assign count = wr_ptr - rd_ptr;
  assign empty = (count == '0);
  assign full  = (count == (AW+1)'(DEPTH));

  assert_no_push_full_R9: assert property (@(posedge clk) disable iff (rst)
    full |-> !push);
  assert_no_pop_empty_R8: assert property (@(posedge clk) disable iff (rst)
    empty |-> !pop);
endmodule

// File: rtl/spibm_shifter.sv
module spibm_shifter #(
  parameter int FRAME_W = 8,
  parameter int DIV_W   = 8,
  localparam int IDX_W  = $clog2(FRAME_W),
  localparam int EDGE_W = $clog2(2*FRAME_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] tx_byte,
  input  logic               cpol,
  input  logic               cpha,
  input  logic               lsb_first,
  input  logic [DIV_W-1:0]   divisor,
  input  logic               miso,
  output logic               busy,
  output logic               sclk,
  output logic               mosi,
  output logic               rx_valid,
  output logic [FRAME_W-1:0] rx_byte
);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2*FRAME_W-1);

  logic [DIV_W-1:0]   div_cnt;
  logic [EDGE_W-1:0]  edge_cnt;
  logic [IDX_W-1:0]   out_idx, in_idx;
  logic [FRAME_W-1:0] tx_q, rx_q, rx_next;
  logic               tick, lead, shift_now, sample_now, last_edge;

  function automatic logic [IDX_W-1:0] bitpos(input logic lsb, input logic [IDX_W-1:0] i);
    return lsb ? i : (IDX_W'(FRAME_W-1) - i);
  endfunction

  always_comb begin
    tick       = busy && (div_cnt == divisor);
    lead       = !edge_cnt[0];
    shift_now  = tick && (cpha ? lead : !lead);
    sample_now = tick && (cpha ? !lead : lead);
    last_edge  = tick && (edge_cnt == LAST_EDGE);
    rx_next    = rx_q;
    if (sample_now) rx_next[bitpos(lsb_first, in_idx)] = miso;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      sclk     <= 1'b0;
      mosi     <= 1'b0;
      div_cnt  <= '0;
      edge_cnt <= '0;
      out_idx  <= '0;
      in_idx   <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (!busy) begin
        sclk <= cpol;
        if (start) begin
          busy     <= 1'b1;
          tx_q     <= tx_byte;
          mosi     <= tx_byte[bitpos(lsb_first, '0)];
          out_idx  <= cpha ? IDX_W'(0) : IDX_W'(1);
          in_idx   <= '0;
          div_cnt  <= '0;
          edge_cnt <= '0;
        end
      end else if (tick) begin
        div_cnt  <= '0;
        sclk     <= ~sclk;
        edge_cnt <= edge_cnt + 1'b1;
        rx_q     <= rx_next;
        if (shift_now && !last_edge) begin
          mosi    <= tx_q[bitpos(lsb_first, out_idx)];
          out_idx <= out_idx + 1'b1;
        end
        if (sample_now) in_idx <= in_idx + 1'b1;
        if (last_edge) begin
          busy     <= 1'b0;
          rx_valid <= 1'b1;
          rx_byte  <= rx_next;
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  // R5: between frames the clock rests at the polarity level
  assert_sclk_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (!busy && $stable(cpol) && !$rose(cpol) && !$fell(cpol) && $past(!busy)) |-> sclk == cpol);
  // R6: data out never moves in a cycle where the clock holds still
  assert_mosi_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && $stable(sclk)) |-> $stable(mosi));
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spibm_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int FRAME_W    = 8,
  parameter int DIV_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  localparam int THR_W = $clog2(FIFO_DEPTH);
  localparam int CNT_W = THR_W + 1;

  logic             active_q, lsb_q, cpol_q, cpha_q, irq_en_q, ovf_q;
  logic [THR_W-1:0] thr_q;
  logic [DIV_W-1:0] div_q;
  logic [LEN_W-1:0] len_q;

  logic wr_mode, wr_frame, wr_clk, wr_data, rd_data, clr_bufs;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic [CNT_W-1:0] tx_count, rx_count;
  logic [FRAME_W-1:0] tx_head, rx_head, rx_byte;
  logic rx_valid, busy, start, tx_push, rx_push, rx_pop, rx_ready;
  logic [REG_W-1:0] rd_mux, status;

  always_comb begin
    wr_mode  = bus_wr && (bus_addr == A_MODE);
    wr_frame = bus_wr && (bus_addr == A_FRAME)  && !active_q;
    wr_clk   = bus_wr && (bus_addr == A_CLKLEN) && !active_q;
    wr_data  = bus_wr && (bus_addr == A_DATA);
    rd_data  = bus_rd && (bus_addr == A_DATA);
    clr_bufs = wr_mode && !bus_wdata[MD_ACT] && bus_wdata[MD_CLR];
    tx_push  = wr_data && !tx_full && !clr_bufs;
    rx_push  = rx_valid && !rx_full && !clr_bufs;
    rx_pop   = rd_data && !rx_empty && !clr_bufs;
    start    = active_q && !tx_empty && !busy;
    rx_ready = rx_count >= ({1'b0, thr_q} + 1'b1);
  end

  spibm_fifo #(.W(FRAME_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .clr(clr_bufs),
    .push(tx_push), .wdata(bus_wdata[FRAME_W-1:0]),
    .pop(start), .rdata(tx_head),
    .full(tx_full), .empty(tx_empty), .count(tx_count));

  spibm_fifo #(.W(FRAME_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .clr(clr_bufs),
    .push(rx_push), .wdata(rx_byte),
    .pop(rx_pop), .rdata(rx_head),
    .full(rx_full), .empty(rx_empty), .count(rx_count));

  spibm_shifter #(.FRAME_W(FRAME_W), .DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst(rst), .start(start), .tx_byte(tx_head),
    .cpol(cpol_q), .cpha(cpha_q), .lsb_first(lsb_q), .divisor(div_q),
    .miso(miso), .busy(busy), .sclk(sclk), .mosi(mosi),
    .rx_valid(rx_valid), .rx_byte(rx_byte));

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      lsb_q    <= 1'b0;
      cpol_q   <= 1'b0;
      cpha_q   <= 1'b0;
      irq_en_q <= 1'b0;
      thr_q    <= '0;
      div_q    <= '0;
      len_q    <= LEN_W'(FRAME_W);
      ovf_q    <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (wr_mode) active_q <= bus_wdata[MD_ACT];
      if (wr_frame) begin
        lsb_q    <= bus_wdata[FR_LSB];
        cpol_q   <= bus_wdata[FR_CPOL];
        cpha_q   <= bus_wdata[FR_CPHA];
        irq_en_q <= bus_wdata[FR_IRQEN];
        thr_q    <= bus_wdata[FR_THR +: THR_W];
      end
      if (wr_clk) begin
        div_q <= bus_wdata[CL_DIV +: DIV_W];
        len_q <= bus_wdata[LEN_W-1:0];
      end
      if (clr_bufs)                  ovf_q <= 1'b0;
      else if (wr_data && tx_full)   ovf_q <= 1'b1;
      irq <= irq_en_q && rx_ready;
    end
  end

  always_comb begin
    status = '0;
    status[ST_IDLE]  = !busy && tx_empty;
    status[ST_RXRDY] = rx_ready;
    status[ST_OVF]   = ovf_q;
    status[ST_TXFUL] = tx_full;
    status[ST_RXEMP] = rx_empty;
    status[ST_ACT]   = active_q;
    rd_mux = '0;
    unique case (bus_addr)
      A_MODE:   rd_mux[MD_ACT] = active_q;
      A_FRAME: begin
        rd_mux[FR_LSB]   = lsb_q;
        rd_mux[FR_CPOL]  = cpol_q;
        rd_mux[FR_CPHA]  = cpha_q;
        rd_mux[FR_IRQEN] = irq_en_q;
        rd_mux[FR_THR +: THR_W] = thr_q;
      end
      A_CLKLEN: begin
        rd_mux[CL_DIV +: DIV_W] = div_q;
        rd_mux[LEN_W-1:0]       = len_q;
      end
      A_STAT:   rd_mux = status;
      A_DATA:   rd_mux[FRAME_W-1:0] = rx_empty ? '0 : rx_head;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  logic unused_bits;
  assign unused_bits = ^{bus_wdata, tx_count};

  // R2: configuration is frozen while active
  assert_cfg_locked_R2: assert property (@(posedge clk) disable iff (rst)
    active_q |=> $stable({lsb_q, cpol_q, cpha_q, irq_en_q, thr_q, div_q, len_q}));
  // R4: a frame only starts in active mode
  assert_no_shift_config_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(active_q));
  // R11: interrupt needs the enable bit
  assert_irq_enable_R11: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irq_en_q));
  // R9: overflow flag is sticky until a clearing mode write
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !clr_bufs) |=> ovf_q);
endmodule

// File: tb/spi_burst_master_tb.sv
module spi_burst_master_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic irq, sclk, mosi;
  logic miso = 1'b0;

  always #2 clk = ~clk;

  spi_burst_master u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso));

  int tests = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- slave model ----------------
  logic tb_cpol = 0, tb_cpha = 0, tb_lsb = 0, slv_arm = 0;
  logic [7:0] slv_tx [0:8];
  logic [7:0] slv_got [0:8];
  logic [7:0] scap;
  int sbit = 0, slv_ti = 0, slv_gn = 0;

  function automatic int bp(input int i);
    return tb_lsb ? i : 7 - i;
  endfunction

  always @(sclk) begin
    if (slv_arm) begin
      if (sclk != tb_cpol) begin
        if (!tb_cpha) scap[bp(sbit)] = mosi;
        else miso = slv_tx[slv_ti][bp(sbit)];
      end else begin
        if (tb_cpha) scap[bp(sbit)] = mosi;
        sbit++;
        if (sbit == 8) begin
          slv_got[slv_gn] = scap;
          slv_gn++;
          slv_ti++;
          sbit = 0;
        end
        if (!tb_cpha) miso = slv_tx[slv_ti][bp(sbit)];
      end
    end
  end

  task automatic arm();
    sbit = 0; slv_ti = 0; slv_gn = 0;
    miso = slv_tx[0][bp(0)];
    slv_arm = 1;
  endtask

  // ---------------- SCLK timing monitor ----------------
  bit meas_on = 0, seen = 0;
  logic prev_sclk = 0;
  int hcnt = 0, hmin = 1000, hmax = 0, toggles = 0;

  always @(negedge clk) begin
    if (meas_on) begin
      if (sclk != prev_sclk) begin
        if (seen) begin
          if (hcnt < hmin) hmin = hcnt;
          if (hcnt > hmax) hmax = hcnt;
        end
        seen = 1; hcnt = 1; toggles++;
      end else hcnt++;
    end
    prev_sclk = sclk;
  end

  task automatic meas_start();
    seen = 0; hcnt = 0; hmin = 1000; hmax = 0; toggles = 0; meas_on = 1;
  endtask

  // ---------------- bus tasks ----------------
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [15:0] s;
    int n = 0;
    do begin rd(3'd3, s); n++; end while (!s[0] && n < 3000);
    chk(tag, s[0], 1);
  endtask

  function automatic logic [15:0] frame(input int cpol, input int cpha, input int lsb,
                                        input int thr, input int en);
    return 16'((thr << 12) | (en << 3) | (cpha << 2) | (cpol << 1) | lsb);
  endfunction

  // vectors: [26] cpol [25] cpha [24] lsb [23:16] divisor [15:8] tx [7:0] slave byte
  localparam logic [26:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 8'd0, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 1'b0, 8'd1, 8'h5A, 8'hC3},
    {1'b1, 1'b0, 1'b0, 8'd2, 8'h81, 8'h7E},
    {1'b1, 1'b1, 1'b0, 8'd0, 8'hF0, 8'h0F},
    {1'b0, 1'b0, 1'b1, 8'd1, 8'h12, 8'h48},
    {1'b0, 1'b1, 1'b1, 8'd3, 8'h6B, 8'hD9},
    {1'b1, 1'b0, 1'b1, 8'd0, 8'h01, 8'h80},
    {1'b1, 1'b1, 1'b1, 8'd2, 8'hE7, 8'h24}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1 reset values
    chk("R1 sclk", sclk, 0);
    chk("R1 irq", irq, 0);
    rd(3'd0, d); chk("R1 mode", d, 16'h0000);
    rd(3'd1, d); chk("R1 frame", d, 16'h0000);
    rd(3'd2, d); chk("R1 clklen", d, 16'h0008);
    rd(3'd3, d); chk("R1/R12 status", d, 16'h0011);

    // vector table: modes, bit orders, divisors (R5 R6 R7 R8)
    for (int i = 0; i < 8; i++) begin
      logic [26:0] v;
      v = VEC[i];
      wr(3'd0, 16'h0002);
      wr(3'd1, frame(v[26], v[25], v[24], 0, 0));
      wr(3'd2, {v[23:16], 8'h08});
      tb_cpol = v[26]; tb_cpha = v[25]; tb_lsb = v[24];
      slv_tx[0] = v[7:0];
      repeat (3) @(negedge clk);
      arm();
      meas_start();
      wr(3'd0, 16'h0001);
      wr(3'd4, {8'h00, v[15:8]});
      wait_idle("R12 idle after frame");
      repeat (4) @(negedge clk);
      meas_on = 0;
      chk($sformatf("R5 v%0d toggles", i), toggles, 16);
      chk($sformatf("R5 v%0d half min", i), hmin, int'(v[23:16]) + 1);
      chk($sformatf("R5 v%0d half max", i), hmax, int'(v[23:16]) + 1);
      chk($sformatf("R5 v%0d idle level", i), sclk, v[26]);
      chk($sformatf("R6/R7 v%0d slave got", i), slv_got[0], v[15:8]);
      rd(3'd4, d);
      chk($sformatf("R6/R7/R8 v%0d rx", i), d, {8'h00, v[7:0]});
      slv_arm = 0;
    end

    // R2 writes ignored while active
    wr(3'd0, 16'h0002);
    wr(3'd1, 16'h0006);
    wr(3'd2, 16'h0308);
    wr(3'd0, 16'h0001);
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'h0108);
    rd(3'd1, d); chk("R2 frame locked", d, 16'h0006);
    rd(3'd2, d); chk("R2 clklen locked", d, 16'h0308);

    // R4 / R9 staging in config mode with overflow
    wr(3'd0, 16'h0002);
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'h0008);
    tb_cpol = 0; tb_cpha = 0; tb_lsb = 0;
    repeat (3) @(negedge clk);
    meas_start();
    for (int k = 0; k < 5; k++) wr(3'd4, 16'(8'hA1 + k));
    repeat (20) @(negedge clk);
    meas_on = 0;
    chk("R4 no toggles in config", toggles, 0);
    rd(3'd3, d); chk("R9/R12 status staged", d, 16'h001C);
    slv_tx[0] = 8'h11; slv_tx[1] = 8'h22; slv_tx[2] = 8'h33; slv_tx[3] = 8'h44;
    arm();
    wr(3'd0, 16'h0001);
    wait_idle("R4 drained");
    repeat (4) @(negedge clk);
    chk("R9 four sent", slv_gn, 4);
    for (int k = 0; k < 4; k++) chk("R9 sent byte", slv_got[k], 8'hA1 + k);
    for (int k = 0; k < 4; k++) begin
      rd(3'd4, d); chk("R8 rx order", d, 16'(8'h11 * (k + 1)));
    end
    rd(3'd4, d); chk("R8 empty read", d, 0);
    rd(3'd3, d); chk("R9 overflow sticky", d[2], 1);
    slv_arm = 0;
    wr(3'd0, 16'h0002);
    rd(3'd3, d); chk("R3 overflow cleared", d, 16'h0011);

    // R3 clear discards staged bytes
    wr(3'd4, 16'h0055);
    wr(3'd4, 16'h0066);
    wr(3'd0, 16'h0002);
    rd(3'd3, d); chk("R3 status after clear", d, 16'h0011);
    meas_start();
    wr(3'd0, 16'h0001);
    repeat (40) @(negedge clk);
    meas_on = 0;
    chk("R3 nothing sent", toggles, 0);
    rd(3'd3, d); chk("R12 active idle", d, 16'h0031);

    // R10 / R11 threshold and interrupt
    wr(3'd0, 16'h0002);
    wr(3'd1, frame(0, 0, 0, 2, 1));
    slv_tx[0] = 8'h01; slv_tx[1] = 8'h02; slv_tx[2] = 8'h03;
    repeat (3) @(negedge clk);
    arm();
    wr(3'd0, 16'h0001);
    wr(3'd4, 16'h0070);
    wr(3'd4, 16'h0071);
    wait_idle("R10 two sent");
    repeat (3) @(negedge clk);
    rd(3'd3, d); chk("R10 not ready at 2", d[1], 0);
    chk("R11 irq low at 2", irq, 0);
    wr(3'd4, 16'h0072);
    wait_idle("R10 three sent");
    repeat (3) @(negedge clk);
    rd(3'd3, d); chk("R10 ready at 3", d[1], 1);
    chk("R11 irq high", irq, 1);
    rd(3'd4, d); chk("R8 first of burst", d, 16'h0001);
    repeat (3) @(negedge clk);
    chk("R11 irq drops", irq, 0);
    rd(3'd3, d); chk("R10 ready drops", d[1], 0);
    slv_arm = 0;
    wr(3'd0, 16'h0000);
    wr(3'd1, frame(0, 0, 0, 0, 0));
    repeat (3) @(negedge clk);
    rd(3'd3, d); chk("R10 ready at thr0", d[1], 1);
    chk("R11 irq gated off", irq, 0);
    wr(3'd0, 16'h0002);
    rd(3'd3, d); chk("R3 rx cleared", d, 16'h0011);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule